// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Receiver

This peripheral watches a demodulated infrared line and turns each pulse of the line into a measured symbol. A symbol starts when the line falls. The low phase is timed first and the high phase second, both in prescaled ticks. The next falling edge closes the symbol, and the finished pair of widths is packed into one 32-bit word. The words wait in a 16-entry FIFO until software reads them through a small synchronous register port.

A line that stays high ends the stream. Once the low and high widths of the open symbol together reach a programmable maximum, the symbol is closed with its high width clipped and a timeout is flagged. If the FIFO is full, a new symbol is dropped and an overflow flag is raised. The stored symbols stay in place and are drained by ordinary reads. Three sticky events (received, timeout and overflow) each have a mask bit and a write-one clear bit, and a single interrupt line combines the unmasked ones.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset, the registers read as follows: enable 0, busy 0, count 0, status 0, mask 0x0000_0700 and configuration 0x3E80_0080. irq_o is low.
- R2: A write of 1 to bit 0 of the enable register (0x00) while the receiver is off makes the busy register (0x1C) read 1 for BUSY_CYCLES cycles. After that it reads 0.
- R3: Capture runs only after a write to the start register (0x34) made while enabled. Writing 0 to enable stops capture and returns the measurement to idle. While stopped, line activity pushes nothing.
- R4: Configuration bits 6:0 hold P, and a tick occurs every P+1 clocks while capturing. A falling edge on the synchronized line opens a symbol. Each phase counter starts at 1 if the edge cycle is a tick and at 0 otherwise. It then adds one on every later tick in that phase and saturates at 0xFFFF.
- R5: The next falling edge pushes a word with the low width in bits 15:0 and the high width in bits 31:16, then opens a new symbol at once.
- R6: In the high phase, a non-edge tick that brings low plus high to at least the maximum width (configuration bits 31:16) pushes the word carrying that high value, sets timeout and returns to idle. Idle waits for the next falling edge.
- R7: The count register (0x20) returns the FIFO occupancy. A read of the data register (0x24) returns the oldest word and removes it. Reading the data register while the FIFO is empty returns 0 and changes nothing.
- R8: A push into a full FIFO with no pop in the same cycle is dropped and sets overflow. All 16 stored words stay readable in order.
- R9: The received flag is set by an accepted push after which the count is at least configuration bits 13:8 plus one.
- R10: Status (0x2C) shows raw received, timeout and overflow in bits 8, 9 and 10. The same flags gated by the mask appear in bits 24, 25 and 26. Mask bits 10:8 (0x28) set to 1 hide the matching event, and irq_o is the OR of the gated flags.
- R11: Writing 1 to bits 16, 17 or 18 of the clear register (0x30) clears received, timeout or overflow. A flag that is set in the same cycle stays set.
- R12: The configuration register (0x04) reads back exactly the last value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated infrared line, idle high |
| addr_i | input | ADDR_W | Byte offset of the register |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (pops the FIFO when it targets the data register) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is overflow while symbols are still arriving. It needs sixteen completed symbols, so at least seventeen falling edges, with no reads in between, and then a further push that must be dropped while the stored words stay intact. The stimulus disables reads, drives a long train of two-cycle pulses, and then drains the FIFO word by word against a behavioural queue. The timeout closing is exercised with the prescaler both bypassed and active, so that the clipped high width lands on different tick phases.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int unsigned REG_AW = 6;

  localparam logic [REG_AW-1:0] ADR_ENABLE = 6'h00;
  localparam logic [REG_AW-1:0] ADR_CONFIG = 6'h04;
  localparam logic [REG_AW-1:0] ADR_BUSY   = 6'h1C;
  localparam logic [REG_AW-1:0] ADR_COUNT  = 6'h20;
  localparam logic [REG_AW-1:0] ADR_DATA   = 6'h24;
  localparam logic [REG_AW-1:0] ADR_MASK   = 6'h28;
  localparam logic [REG_AW-1:0] ADR_STATUS = 6'h2C;
  localparam logic [REG_AW-1:0] ADR_CLEAR  = 6'h30;
  localparam logic [REG_AW-1:0] ADR_START  = 6'h34;

  localparam logic [31:0] CFG_RESET = 32'h3E80_0080;

  // event bit order inside status, mask and clear fields
  localparam int unsigned EV_RCV = 0;
  localparam int unsigned EV_TMO = 1;
  localparam int unsigned EV_OVF = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RESET_VAL}};
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ir_cap_meter.sv
module ir_cap_meter
  import ir_cap_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PRE_W = 7,
  localparam int unsigned WORD_W = 2 * CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              line_i,
  input  logic [PRE_W-1:0]  presc_i,
  input  logic [CNT_W-1:0]  max_w_i,
  output logic              push_o,
  output logic [WORD_W-1:0] word_o,
  output logic              timeout_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  phase_e            phase_q, phase_d;
  logic              line_d_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  low_q, low_d, high_q, high_d;
  logic              tick, fall, rise, hit;
  logic [CNT_W-1:0]  low_inc, high_inc;
  logic [CNT_W:0]    width_sum;

  assign fall     = line_d_q & ~line_i;
  assign rise     = ~line_d_q & line_i;
  assign tick     = active_i && (pre_q == presc_i);
  assign low_inc  = (low_q == CNT_MAX) ? low_q : low_q + 1'b1;
  assign high_inc = (high_q == CNT_MAX) ? high_q : high_q + 1'b1;
  assign width_sum = {1'b0, low_q} + {1'b0, high_inc};
  assign hit      = width_sum >= {1'b0, max_w_i};

  always_comb begin
    phase_d   = phase_q;
    low_d     = low_q;
    high_d    = high_q;
    push_o    = 1'b0;
    timeout_o = 1'b0;
    word_o    = {high_q, low_q};
    if (!active_i) begin
      phase_d = PH_IDLE;
      low_d   = '0;
      high_d  = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (fall) begin
          phase_d = PH_LOW;
          low_d   = {{(CNT_W-1){1'b0}}, tick};
        end
        PH_LOW: begin
          if (rise) begin
            phase_d = PH_HIGH;
            high_d  = {{(CNT_W-1){1'b0}}, tick};
          end else if (tick) begin
            low_d = low_inc;
          end
        end
        PH_HIGH: begin
          if (fall) begin
            push_o  = 1'b1;
            phase_d = PH_LOW;
            low_d   = {{(CNT_W-1){1'b0}}, tick};
          end else if (tick) begin
            if (hit) begin
              push_o    = 1'b1;
              timeout_o = 1'b1;
              word_o    = {high_inc, low_q};
              phase_d   = PH_IDLE;
            end else begin
              high_d = high_inc;
            end
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      line_d_q <= 1'b1;
      pre_q    <= '0;
      low_q    <= '0;
      high_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      line_d_q <= line_i;
      pre_q    <= (!active_i || tick) ? '0 : pre_q + 1'b1;
      low_q    <= low_d;
      high_q   <= high_d;
    end
  end

  assert_stop_idles_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> phase_q == PH_IDLE);
  assert_timeout_ends_stream_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !push_o && phase_q == PH_IDLE);
endmodule

// File: rtl/ir_cap_fifo.sv
module ir_cap_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             accept_o,
  output logic             drop_o,
  output logic             pop_ok_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             full, empty;

  assign full     = count_q == FULL_CNT;
  assign empty    = count_q == '0;
  assign pop_ok_o = pop_i && !empty;
  assign accept_o = push_i && (!full || pop_ok_o);
  assign drop_o   = push_i && !accept_o;
  assign head_o   = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o  = count_q;

  always_ff @(posedge clk_i) begin
    if (accept_o) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (accept_o) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok_o) rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      count_q <= count_q + CNT_W'(accept_o) - CNT_W'(pop_ok_o);
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  assert_drop_keeps_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> count_o == FULL_CNT);
  assert_empty_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> count_o == '0);
endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
  import ir_cap_pkg::*;
#(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned BUSY_CYCLES = 4,
  parameter int unsigned ADDR_W      = REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ir_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int unsigned SYM_W  = 16;

  logic              en_q, run_q;
  logic [31:0]       cfg_q;
  logic [2:0]        mask_q, st_q, st_set, st_clr;
  logic [BUSY_W-1:0] busy_q;
  logic              active, line_s;
  logic              sym_push, sym_tmo;
  logic [2*SYM_W-1:0] sym_word, head;
  logic [CNT_W-1:0]  count;
  logic              accept, drop, pop_ok, pop_req, rcv_set;
  logic [CNT_W:0]    count_after;
  logic [6:0]        rcv_thr;
  logic              wr_en, wr_cfg, wr_mask, wr_clr, wr_start;

  assign wr_en    = wr_i && addr_i == ADDR_W'(ADR_ENABLE);
  assign wr_cfg   = wr_i && addr_i == ADDR_W'(ADR_CONFIG);
  assign wr_mask  = wr_i && addr_i == ADDR_W'(ADR_MASK);
  assign wr_clr   = wr_i && addr_i == ADDR_W'(ADR_CLEAR);
  assign wr_start = wr_i && addr_i == ADDR_W'(ADR_START);
  assign pop_req  = rd_i && addr_i == ADDR_W'(ADR_DATA);
  assign active   = en_q & run_q;

  ir_cap_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ir_i),
    .q_o   (line_s)
  );

  ir_cap_meter #(.CNT_W(SYM_W), .PRE_W(7)) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .line_i   (line_s),
    .presc_i  (cfg_q[6:0]),
    .max_w_i  (cfg_q[31:16]),
    .push_o   (sym_push),
    .word_o   (sym_word),
    .timeout_o(sym_tmo)
  );

  ir_cap_fifo #(.WIDTH(2*SYM_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (sym_push),
    .data_i  (sym_word),
    .pop_i   (pop_req),
    .head_o  (head),
    .count_o (count),
    .accept_o(accept),
    .drop_o  (drop),
    .pop_ok_o(pop_ok)
  );

  // occupancy after this edge decides the received event
  assign count_after = {1'b0, count} + (CNT_W+1)'(accept) - (CNT_W+1)'(pop_ok);
  assign rcv_thr     = {1'b0, cfg_q[13:8]} + 7'd1;
  assign rcv_set     = accept && (32'(count_after) >= 32'(rcv_thr));

  always_comb begin
    st_set         = '0;
    st_set[EV_RCV] = rcv_set;
    st_set[EV_TMO] = sym_tmo;
    st_set[EV_OVF] = drop;
    st_clr         = wr_clr ? wdata_i[18:16] : 3'b000;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      cfg_q  <= CFG_RESET;
      mask_q <= 3'b111;
      st_q   <= '0;
      busy_q <= '0;
    end else begin
      st_q <= st_set | (st_q & ~st_clr);
      if (wr_en) begin
        en_q <= wdata_i[0];
        if (!wdata_i[0]) run_q <= 1'b0;
      end
      if (wr_start) run_q <= en_q;
      if (wr_cfg)   cfg_q <= wdata_i;
      if (wr_mask)  mask_q <= wdata_i[10:8];
      if (wr_en && wdata_i[0] && !en_q) busy_q <= BUSY_W'(BUSY_CYCLES);
      else if (busy_q != '0)            busy_q <= busy_q - 1'b1;
    end
  end

  assign irq_o = |(st_q & ~mask_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(ADR_ENABLE): rdata_o = {31'b0, en_q};
      ADDR_W'(ADR_CONFIG): rdata_o = cfg_q;
      ADDR_W'(ADR_BUSY):   rdata_o = {31'b0, busy_q != '0};
      ADDR_W'(ADR_COUNT):  rdata_o = 32'(count);
      ADDR_W'(ADR_DATA):   rdata_o = head;
      ADDR_W'(ADR_MASK):   rdata_o = {21'b0, mask_q, 8'b0};
      ADDR_W'(ADR_STATUS): rdata_o = {5'b0, st_q & ~mask_q, 13'b0, st_q, 8'b0};
      default:             rdata_o = '0;
    endcase
  end

  assert_busy_on_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q) |-> busy_q != '0);
  assert_ovf_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[EV_OVF] && !(wr_clr && wdata_i[18])) |=> st_q[EV_OVF]);
  assert_set_beats_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> st_q[EV_OVF]);
  assert_mask_all_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 3'b111) |-> !irq_o);
endmodule

// File: tb/tb_ir_capture_rx.sv
module tb_ir_capture_rx;
  localparam int BUSY_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir = 1'b1;
  logic [5:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int vectors = 0, fails = 0;
  bit ready = 0;

  always #2.5 clk = ~clk;

  ir_capture_rx #(.DEPTH(16), .BUSY_CYCLES(BUSY_CYCLES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  bit          m_en, m_run, m_s1, m_s2, m_sd;
  int          m_busy, m_pre, m_ph, m_lo, m_hi;
  logic [31:0] m_cfg;
  bit   [2:0]  m_mask, m_st;
  logic [31:0] m_q[$];

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return {31'b0, m_en};
      6'h04: return m_cfg;
      6'h1C: return {31'b0, m_busy != 0};
      6'h20: return 32'(m_q.size());
      6'h24: return (m_q.size() != 0) ? m_q[0] : 32'h0;
      6'h28: return {21'b0, m_mask, 8'b0};
      6'h2C: return {5'b0, m_st & ~m_mask, 13'b0, m_st, 8'b0};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_run = 0; m_s1 = 1; m_s2 = 1; m_sd = 1;
      m_busy = 0; m_pre = 0; m_ph = 0; m_lo = 0; m_hi = 0;
      m_cfg = 32'h3E80_0080; m_mask = 3'b111; m_st = 0; m_q.delete();
    end else begin
      bit act, tick, fall, rise, push, tmo, pop, accept, drop, rcv;
      int hn;
      logic [31:0] word;
      bit [2:0] clr;
      act = m_en && m_run;
      tick = act && (m_pre == int'(m_cfg[6:0]));
      fall = m_sd && !m_s2;
      rise = !m_sd && m_s2;
      push = 0; tmo = 0; word = 0;
      if (!act) begin m_ph = 0; m_lo = 0; m_hi = 0; end
      else if (m_ph == 0) begin
        if (fall) begin m_ph = 1; m_lo = int'(tick); end
      end else if (m_ph == 1) begin
        if (rise) begin m_ph = 2; m_hi = int'(tick); end
        else if (tick && m_lo < 65535) m_lo++;
      end else begin
        if (fall) begin
          push = 1; word = {m_hi[15:0], m_lo[15:0]}; m_ph = 1; m_lo = int'(tick);
        end else if (tick) begin
          hn = (m_hi < 65535) ? m_hi + 1 : m_hi;
          if (m_lo + hn >= int'(m_cfg[31:16])) begin
            push = 1; tmo = 1; word = {hn[15:0], m_lo[15:0]}; m_ph = 0;
          end else m_hi = hn;
        end
      end
      m_pre = (!act || tick) ? 0 : m_pre + 1;
      m_sd = m_s2; m_s2 = m_s1; m_s1 = ir;
      pop = rd && addr == 6'h24 && m_q.size() != 0;
      accept = push && (m_q.size() < 16 || pop);
      drop = push && !accept;
      if (pop) void'(m_q.pop_front());
      if (accept) m_q.push_back(word);
      rcv = accept && (m_q.size() >= int'(m_cfg[13:8]) + 1);
      clr = (wr && addr == 6'h30) ? wdata[18:16] : 3'b000;
      m_st = {drop, tmo, rcv} | (m_st & ~clr);
      if (wr && addr == 6'h00 && wdata[0] && !m_en) m_busy = BUSY_CYCLES;
      else if (m_busy > 0) m_busy--;
      if (wr && addr == 6'h34) m_run = m_en;
      if (wr && addr == 6'h00) begin m_en = wdata[0]; if (!wdata[0]) m_run = 0; end
      if (wr && addr == 6'h04) m_cfg = wdata;
      if (wr && addr == 6'h28) m_mask = wdata[10:8];
    end
  end

  // interrupt compared every cycle
  always @(negedge clk) begin
    if (ready) begin
      vectors++;
      if (irq !== (|(m_st & ~m_mask))) begin
        fails++;
        $display("FAIL R10 irq_o actual %0b expected %0b at %0t", irq, |(m_st & ~m_mask), $time);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  // read one register, compare against the model and return the value
  task automatic reg_rd(input logic [5:0] a, input string req, output logic [31:0] v);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 v = rdata;
    check(req, v, m_read(a));
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic line(input bit v, input int n);
    @(negedge clk); ir = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ready = 1;
    // R1 reset values
    reg_rd(6'h00, "R1 enable", v);  check("R1 enable lit", v, 32'h0);
    reg_rd(6'h04, "R1 config", v);  check("R1 config lit", v, 32'h3E80_0080);
    reg_rd(6'h2C, "R1 status", v);  check("R1 status lit", v, 32'h0);
    reg_rd(6'h28, "R1 mask", v);    check("R1 mask lit", v, 32'h700);
    reg_rd(6'h20, "R1 count", v);
    reg_rd(6'h1C, "R1 busy", v);
    // R2 busy after enable
    reg_wr(6'h00, 32'h1);
    reg_rd(6'h1C, "R2 busy set", v); check("R2 busy lit", v, 32'h1);
    repeat (5) @(negedge clk);
    reg_rd(6'h1C, "R2 busy done", v); check("R2 busy idle lit", v, 32'h0);
    // R12 config: max width 40, level 0, raw, prescale 0
    reg_wr(6'h04, 32'h0028_0080);
    reg_rd(6'h04, "R12 config", v); check("R12 config lit", v, 32'h0028_0080);
    // R3 no capture before start
    line(0, 4); line(1, 50);
    reg_rd(6'h20, "R3 count before start", v); check("R3 lit", v, 32'h0);
    reg_wr(6'h28, 32'h0);
    reg_wr(6'h34, 32'h1);
    // R4 R5 R6 symbol train ending in a timeout
    line(0, 5); line(1, 8); line(0, 3); line(1, 10); line(0, 6); line(1, 60);
    reg_rd(6'h20, "R7 count", v); check("R7 count lit", v, 32'd3);
    reg_rd(6'h2C, "R10 status", v);
    reg_rd(6'h24, "R5 word0", v); check("R5 word0 lit", v, 32'h0008_0005);
    reg_rd(6'h24, "R5 word1", v); check("R5 word1 lit", v, 32'h000A_0003);
    reg_rd(6'h24, "R6 timeout word", v); check("R6 clipped lit", v, 32'h0022_0006);
    reg_rd(6'h24, "R7 empty read", v); check("R7 empty lit", v, 32'h0);
    // R11 clear received and timeout
    reg_wr(6'h30, 32'h0003_0000);
    reg_rd(6'h2C, "R11 cleared", v); check("R11 cleared lit", v, 32'h0);
    // R8 overflow with 2-cycle pulses, no reads
    for (int i = 0; i < 19; i++) begin line(0, 2); line(1, 2); end
    line(1, 60);
    reg_rd(6'h20, "R8 count full", v); check("R8 full lit", v, 32'd16);
    reg_rd(6'h2C, "R8 status", v); check("R8 ovf raw", v & 32'h400, 32'h400);
    for (int i = 0; i < 16; i++) reg_rd(6'h24, "R8 drain", v);
    reg_rd(6'h20, "R8 drained", v);
    reg_wr(6'h30, 32'h0007_0000);
    reg_rd(6'h2C, "R11 all cleared", v);
    // R10 masked events keep irq low
    reg_wr(6'h28, 32'h700);
    line(0, 4); line(1, 60);
    reg_rd(6'h2C, "R10 masked status", v);
    reg_rd(6'h24, "R10 drain", v);
    reg_wr(6'h30, 32'h0007_0000);
    reg_wr(6'h28, 32'h100);   // hide timeout-free view: only received masked
    reg_wr(6'h28, 32'h0);
    // R9 level 3: received only from fourth stored word
    reg_wr(6'h04, 32'h0028_0380);
    for (int i = 0; i < 3; i++) begin line(0, 3); line(1, 3); end
    reg_rd(6'h2C, "R9 below level", v); check("R9 below lit", v & 32'h100, 32'h0);
    line(0, 3); line(1, 3); line(0, 3);
    reg_rd(6'h2C, "R9 at level", v); check("R9 at lit", v & 32'h100, 32'h100);
    line(1, 60);
    for (int i = 0; i < 5; i++) reg_rd(6'h24, "R9 drain", v);
    reg_wr(6'h30, 32'h0007_0000);
    // R4 prescaler 2 (tick every 3 clocks)
    reg_wr(6'h04, 32'h0028_0082);
    line(0, 9); line(1, 6); line(0, 7); line(1, 150);
    reg_rd(6'h20, "R4 presc count", v);
    for (int i = 0; i < 2; i++) reg_rd(6'h24, "R4 presc word", v);
    reg_wr(6'h30, 32'h0007_0000);
    // R3 disable stops capture
    reg_wr(6'h00, 32'h0);
    line(0, 5); line(1, 5); line(0, 5); line(1, 60);
    reg_rd(6'h20, "R3 stopped count", v); check("R3 stopped lit", v, 32'h0);
    reg_rd(6'h24, "R7 empty after stop", v);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule